// File: doc/BRIEF.md
# Paged Display Memory with Host and Scan Ports

This block holds the dot image of a small matrix display: ten pages of 132 column bytes, where bit i of a byte stored on page p lights common row 8*p + i. A host side reaches the memory one byte at a time through a page pointer and a column pointer. Five operations are available: set the page, set the column, set the segment mirror mode, write a byte, and read a byte. The column pointer steps forward after every host data access and stops at the last column. The page pointer moves only when the host sets it, so moving to another page always takes a new page-set.

A second port serves the display refresh logic. That logic gives a page and a segment index and gets the matching byte back one cycle later. The mirror mode decides which column feeds a given segment. With mirror off, segment s shows column s. With mirror on, segment s shows column 131 − s. Host traffic uses its own port and never disturbs the scan result. When both ports touch the same byte in the same cycle, the scan port returns the byte as it was before the write.

Top module: `paged_disp_ram`

## Requirements
- R1: After reset the page pointer is 0, the column pointer is 0, the mirror mode is 0 and host_rvalid_o is 0.
- R2: Operation code 1 (page set) loads host_arg_i into the page pointer when the value is below 10. A value of 10 or more leaves the page pointer unchanged.
- R3: Operation code 2 (column set) loads host_arg_i into the column pointer. A value above 131 loads 131. The column pointer never exceeds 131.
- R4: Operation code 4 (write) stores host_wdata_i at the current page and column, and the column pointer then advances by one.
- R5: Operation code 5 (read) returns the byte at the current page and column on host_rdata_o in the next cycle, with host_rvalid_o high for exactly that one cycle. The column pointer then advances by one.
- R6: A write or read issued at column 131 uses column 131 and leaves the column pointer at 131. No host data access ever changes the page pointer.
- R7: With mirror mode 0, scan_data_o shows, one cycle after scan_page_i and scan_seg_i are presented, the byte at that page and column scan_seg_i. A segment index above 131 or a page of 10 or more returns 0.
- R8: Operation code 3 sets the mirror mode to host_arg_i bit 0. With mirror mode 1, the scan port returns column 131 − scan_seg_i.
- R9: When a host write and a scan read address the same byte in the same cycle, the scan result holds the previous contents. The new value appears on the next scan of that byte.
- R10: Operation code 0, and codes 6 and 7, change neither pointer, the mirror mode nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_op_i | input | 3 | Host operation code: 0 none, 1 page set, 2 column set, 3 mirror set, 4 write, 5 read |
| host_arg_i | input | 8 | Argument for page, column or mirror set |
| host_wdata_i | input | 8 | Byte to write |
| host_rdata_o | output | 8 | Byte returned by the last read |
| host_rvalid_o | output | 1 | One-cycle pulse marking new read data |
| cur_page_o | output | 4 | Current page pointer |
| cur_col_o | output | 8 | Current column pointer |
| mirror_o | output | 1 | Current mirror mode |
| scan_page_i | input | 4 | Page requested by refresh logic |
| scan_seg_i | input | 8 | Segment index requested by refresh logic |
| scan_data_o | output | 8 | Byte for the requested segment, one cycle later |

## Verification
A faulty pointer shows up on cur_page_o or cur_col_o in the cycle after the operation that disturbed it. Write-address and mapping faults stay hidden until that byte is fetched again. The full sweep therefore reads back every byte of every page through both ports, in both mirror modes, so that a wrong column step, a carry into the page, or a broken saturation lands a byte in the wrong place and fails a compare. Read-before-write ordering on the scan port is checked in the collision cycle itself and again in the cycle that follows.

// File: rtl/disp_ram_pkg.sv
package disp_ram_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PAGE   = 3'd1,
    OP_COL    = 3'd2,
    OP_MIRROR = 3'd3,
    OP_WR     = 3'd4,
    OP_RD     = 3'd5
  } host_op_e;
endpackage

// File: rtl/disp_ptr_ctrl.sv
module disp_ptr_ctrl
  import disp_ram_pkg::*;
#(
  parameter int NUM_PAGES = 10,
  parameter int NUM_COLS  = 132,
  parameter int ARG_W     = 8,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [ARG_W-1:0]  arg_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o,
  output logic              mirror_o,
  output logic              we_o,
  output logic              re_o,
  output logic              rvalid_o
);
  localparam logic [ARG_W-1:0] PAGE_LIM = ARG_W'(NUM_PAGES);
  localparam logic [ARG_W-1:0] LAST_A   = ARG_W'(NUM_COLS - 1);
  localparam logic [COL_W-1:0] LAST_C   = COL_W'(NUM_COLS - 1);

  host_op_e    op;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic              mirror_q, rvalid_q;

  assign op   = host_op_e'(op_i);
  assign we_o = (op == OP_WR);
  assign re_o = (op == OP_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      col_q    <= '0;
      mirror_q <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_o;
      unique case (op)
        OP_PAGE:   if (arg_i < PAGE_LIM) page_q <= arg_i[PAGE_W-1:0];
        OP_COL:    col_q <= (arg_i > LAST_A) ? LAST_C : arg_i[COL_W-1:0];
        OP_MIRROR: mirror_q <= arg_i[0];
        OP_WR, OP_RD: if (col_q != LAST_C) col_q <= col_q + COL_W'(1);  // saturate
        default: ;
      endcase
    end
  end

  assign page_o   = page_q;
  assign col_o    = col_q;
  assign mirror_o = mirror_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/disp_seg_map.sv
module disp_seg_map #(
  parameter int NUM_PAGES = 10,
  parameter int NUM_COLS  = 132,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int AW       = $clog2(NUM_PAGES * NUM_COLS)
) (
  input  logic              mirror_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  seg_i,
  output logic [AW-1:0]     addr_o,
  output logic              oor_o
);
  localparam logic [COL_W-1:0]  LAST_C = COL_W'(NUM_COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_P = PAGE_W'(NUM_PAGES - 1);

  logic [COL_W-1:0] col;

  always_comb begin
    oor_o  = (seg_i > LAST_C) || (page_i > LAST_P);
    col    = mirror_i ? (LAST_C - seg_i) : seg_i;
    addr_o = oor_o ? '0 : (AW'(page_i) * AW'(NUM_COLS) + AW'(col));
  end
endmodule

// File: rtl/disp_mem.sv
module disp_mem #(
  parameter int DEPTH  = 1320,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic [AW-1:0]     scan_addr_i,
  output logic [DATA_W-1:0] scan_rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] host_q, scan_q;

  // nonblocking write: scan port sees pre-write data on a collision
  always_ff @(posedge clk_i) begin
    if (we_i) mem[host_addr_i] <= wdata_i;
    if (re_i) host_q <= mem[host_addr_i];
    scan_q <= mem[scan_addr_i];
  end

  assign host_rdata_o = host_q;
  assign scan_rdata_o = scan_q;
endmodule

// File: rtl/paged_disp_ram.sv
module paged_disp_ram #(
  parameter int NUM_PAGES = 10,
  parameter int NUM_COLS  = 132,
  parameter int DATA_W    = 8,
  parameter int ARG_W     = 8,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        host_op_i,
  input  logic [ARG_W-1:0]  host_arg_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o,
  output logic [PAGE_W-1:0] cur_page_o,
  output logic [COL_W-1:0]  cur_col_o,
  output logic              mirror_o,
  input  logic [PAGE_W-1:0] scan_page_i,
  input  logic [COL_W-1:0]  scan_seg_i,
  output logic [DATA_W-1:0] scan_data_o
);
  localparam int DEPTH = NUM_PAGES * NUM_COLS;
  localparam int AW    = $clog2(DEPTH);

  logic              we, re, mirror, scan_oor, scan_oor_q;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic [AW-1:0]     host_addr, scan_addr;
  logic [DATA_W-1:0] scan_raw;

  disp_ptr_ctrl #(
    .NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS), .ARG_W(ARG_W)
  ) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(host_op_i), .arg_i(host_arg_i),
    .page_o(page), .col_o(col), .mirror_o(mirror),
    .we_o(we), .re_o(re), .rvalid_o(host_rvalid_o)
  );

  assign host_addr = AW'(page) * AW'(NUM_COLS) + AW'(col);

  disp_seg_map #(
    .NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS)
  ) u_map (
    .mirror_i(mirror), .page_i(scan_page_i), .seg_i(scan_seg_i),
    .addr_o(scan_addr), .oor_o(scan_oor)
  );

  disp_mem #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_mem (
    .clk_i(clk_i), .we_i(we), .re_i(re), .host_addr_i(host_addr),
    .wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .scan_addr_i(scan_addr), .scan_rdata_o(scan_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_oor_q <= 1'b1;
    else         scan_oor_q <= scan_oor;
  end

  assign scan_data_o = scan_oor_q ? '0 : scan_raw;
  assign cur_page_o  = page;
  assign cur_col_o   = col;
  assign mirror_o    = mirror;
endmodule

// File: rtl/paged_disp_ram_chk.sv
module paged_disp_ram_chk
  import disp_ram_pkg::*;
#(
  parameter int NUM_PAGES = 10,
  parameter int NUM_COLS  = 132,
  parameter int ARG_W     = 8,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        host_op_i,
  input logic [ARG_W-1:0]  host_arg_i,
  input logic              host_rvalid_o,
  input logic [PAGE_W-1:0] cur_page_o,
  input logic [COL_W-1:0]  cur_col_o,
  input logic              mirror_o
);
  localparam logic [ARG_W-1:0] PAGE_LIM = ARG_W'(NUM_PAGES);
  localparam logic [ARG_W-1:0] LAST_A   = ARG_W'(NUM_COLS - 1);
  localparam logic [COL_W-1:0] LAST_C   = COL_W'(NUM_COLS - 1);

  logic access, quiet;
  assign access = (host_op_i == OP_WR) || (host_op_i == OP_RD);
  assign quiet  = (host_op_i == OP_NOP) || (host_op_i > OP_RD);

  p_page_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_op_i == OP_PAGE && host_arg_i < PAGE_LIM) |=> cur_page_o == $past(host_arg_i[PAGE_W-1:0]));

  p_page_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_op_i == OP_PAGE && host_arg_i >= PAGE_LIM) |=> $stable(cur_page_o));

  p_col_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_op_i == OP_COL) |=>
      cur_col_o == (($past(host_arg_i) > LAST_A) ? LAST_C : $past(host_arg_i[COL_W-1:0])));

  p_col_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_col_o <= LAST_C);

  p_col_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && cur_col_o != LAST_C) |=> cur_col_o == $past(cur_col_o) + COL_W'(1));

  p_rvalid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_op_i == OP_RD) |=> host_rvalid_o);

  p_rvalid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_op_i != OP_RD) |=> !host_rvalid_o);

  p_col_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && cur_col_o == LAST_C) |=> cur_col_o == LAST_C);

  p_no_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access |=> $stable(cur_page_o));

  p_mirror_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_op_i == OP_MIRROR) |=> mirror_o == $past(host_arg_i[0]));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> ($stable(cur_page_o) && $stable(cur_col_o) && $stable(mirror_o)));
endmodule

bind paged_disp_ram paged_disp_ram_chk #(
  .NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS), .ARG_W(ARG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_op_i(host_op_i), .host_arg_i(host_arg_i),
  .host_rvalid_o(host_rvalid_o), .cur_page_o(cur_page_o), .cur_col_o(cur_col_o),
  .mirror_o(mirror_o)
);

// File: tb/tb_paged_disp_ram.sv
module tb_paged_disp_ram;
  localparam int NP = 10;
  localparam int NC = 132;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] host_op_i = 3'd0;
  logic [7:0] host_arg_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       host_rvalid_o;
  logic [3:0] cur_page_o;
  logic [7:0] cur_col_o;
  logic       mirror_o;
  logic [3:0] scan_page_i = '0;
  logic [7:0] scan_seg_i = '0;
  logic [7:0] scan_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [NP][NC];

  always #2 clk_i = ~clk_i;

  paged_disp_ram dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive an op at a negedge, return at the next negedge with state updated
  task automatic op(input logic [2:0] code, input logic [7:0] arg, input logic [7:0] wd);
    host_op_i = code; host_arg_i = arg; host_wdata_i = wd;
    @(negedge clk_i);
    host_op_i = 3'd0;
  endtask

  task automatic scan(input int p, input int s, output logic [7:0] d);
    scan_page_i = 4'(p); scan_seg_i = 8'(s);
    @(negedge clk_i);
    d = scan_data_o;
  endtask

  function automatic logic [7:0] pat(input int p, input int c);
    return 8'((p * 37 + c * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 page", 32'(cur_page_o), 0);
    chk("R1 col", 32'(cur_col_o), 0);
    chk("R1 mirror", 32'(mirror_o), 0);
    chk("R1 rvalid", 32'(host_rvalid_o), 0);

    // R4 fill every page; R6 check saturation and no carry
    for (int p = 0; p < NP; p++) begin
      op(3'd1, 8'(p), 0);
      chk("R2 page load", 32'(cur_page_o), 32'(p));
      op(3'd2, 8'd0, 0);
      for (int c = 0; c < NC; c++) begin
        op(3'd4, 0, pat(p, c));
        model[p][c] = pat(p, c);
        if (c < NC - 1) chk("R4 col step", 32'(cur_col_o), 32'(c + 1));
      end
      chk("R6 col sat", 32'(cur_col_o), 131);
      chk("R6 page hold", 32'(cur_page_o), 32'(p));
    end
    // R6 extra write at the end column lands on column 131
    op(3'd1, 8'd4, 0);
    op(3'd2, 8'd131, 0);
    op(3'd4, 0, 8'hA5);
    op(3'd4, 0, 8'h5A);
    model[4][131] = 8'h5A;
    chk("R6 col stays 131", 32'(cur_col_o), 131);
    chk("R6 page after sat", 32'(cur_page_o), 4);

    // R2 out of range page ignored
    op(3'd1, 8'd10, 0);
    chk("R2 ignore 10", 32'(cur_page_o), 4);
    op(3'd1, 8'd255, 0);
    chk("R2 ignore 255", 32'(cur_page_o), 4);
    op(3'd1, 8'd9, 0);
    chk("R2 load 9", 32'(cur_page_o), 9);

    // R3 column clamp
    op(3'd2, 8'd200, 0);
    chk("R3 clamp 200", 32'(cur_col_o), 131);
    op(3'd2, 8'd132, 0);
    chk("R3 clamp 132", 32'(cur_col_o), 131);
    op(3'd2, 8'd77, 0);
    chk("R3 load 77", 32'(cur_col_o), 77);

    // R10 unused codes change nothing
    op(3'd6, 8'd3, 8'hFF);
    op(3'd7, 8'd1, 8'hFF);
    op(3'd0, 8'd1, 8'hFF);
    chk("R10 page", 32'(cur_page_o), 9);
    chk("R10 col", 32'(cur_col_o), 77);
    chk("R10 mirror", 32'(mirror_o), 0);

    // R5 read back every byte with auto-increment
    for (int p = 0; p < NP; p++) begin
      op(3'd1, 8'(p), 0);
      op(3'd2, 8'd0, 0);
      chk("R5 rvalid idle", 32'(host_rvalid_o), 0);
      for (int c = 0; c < NC; c++) begin
        op(3'd5, 0, 0);
        chk("R5 rvalid", 32'(host_rvalid_o), 1);
        chk("R5 rdata", 32'(host_rdata_o), 32'(model[p][c]));
      end
      op(3'd5, 0, 0);
      chk("R6 read at 131", 32'(host_rdata_o), 32'(model[p][131]));
      chk("R6 col after read", 32'(cur_col_o), 131);
    end
    @(negedge clk_i);
    chk("R5 rvalid drops", 32'(host_rvalid_o), 0);

    // R7 scan with mirror off
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NC; s++) begin
        scan(p, s, d);
        chk("R7 scan", 32'(d), 32'(model[p][s]));
      end
    scan(3, 132, d); chk("R7 seg oor", 32'(d), 0);
    scan(3, 255, d); chk("R7 seg oor 255", 32'(d), 0);
    scan(10, 5, d);  chk("R7 page oor", 32'(d), 0);

    // R8 mirror on
    op(3'd3, 8'd1, 0);
    chk("R8 mirror set", 32'(mirror_o), 1);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NC; s++) begin
        scan(p, s, d);
        chk("R8 scan mirrored", 32'(d), 32'(model[p][NC - 1 - s]));
      end
    op(3'd3, 8'd2, 0);
    chk("R8 mirror clear by bit0", 32'(mirror_o), 0);

    // R9 collision: page 2 col 5, mirror off
    op(3'd1, 8'd2, 0);
    op(3'd2, 8'd5, 0);
    scan_page_i = 4'd2; scan_seg_i = 8'd5;
    host_op_i = 3'd4; host_wdata_i = 8'h3C;
    @(negedge clk_i);
    host_op_i = 3'd0;
    chk("R9 old data", 32'(scan_data_o), 32'(model[2][5]));
    model[2][5] = 8'h3C;
    @(negedge clk_i);
    chk("R9 new data", 32'(scan_data_o), 32'h3C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule